// File: doc/BRIEF.md
# I2C Target with Strapped Address and Power-On Clamp Flag

This block is the serial control port of a register-controlled device. It oversamples the SCL and SDA lines in the system clock domain, finds start and stop conditions, and answers one 7-bit target address. The upper five address bits are fixed at `11011`. A two-bit strap input supplies the lowest two bits, so four copies of the device can share one bus. The block drives SDA only through an open-drain enable: when the enable is high, the line is pulled low.

A write transfer carries a sub-address byte first. The data bytes that follow land in consecutive registers of a small bank, and the pointer wraps at the top of the bank. A read transfer returns status bytes, most significant bit first, from an auto-incrementing pointer that starts at index 0. The master ends a read by answering a byte with NACK.

A power-on flag is high after reset. The first access that matches the address, in either direction, clears it. The flag stays low until the next reset.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, `full_field_o` is 1, `sda_oe_o` is 0 and every register in `regs_o` is 0.
- R2: The block acknowledges an address byte whose upper seven bits equal `{5'b11011, strap_i}`. For strap values 0, 1, 2 and 3 the write bytes are D8h, DAh, DCh and DEh, and the read bytes are D9h, DBh, DDh and DFh. Bit 0 of the address byte is the direction: 0 is write, 1 is read.
- R3: After an address byte that does not match, the block gives no acknowledge and does not drive SDA. Data bytes that follow get no acknowledge and leave the registers unchanged until the next start condition.
- R4: In a write, the first data byte is a sub-address, taken modulo the register count. Each later byte is stored in register `ptr`, at bits `[8*ptr+7 : 8*ptr]` of `regs_o`, and then the pointer increments, wrapping from the last register to register 0.
- R5: When the block receives a byte, it pulls SDA low only during the ninth clock of that byte. `sda_oe_o` changes only while the synchronised SCL is low.
- R6: In a read, byte k of the transfer is the status byte at index `k mod NSTAT`, where index i is at bits `[8*i+7 : 8*i]` of `stat_i`. The byte is sent MSB first. After the master answers with NACK, the block no longer drives SDA.
- R7: The first address match clears `full_field_o`, whether the access is a write or a read. An address that does not match leaves the flag unchanged. Once low, the flag stays low until reset.
- R8: A repeated start at any bit position abandons the current byte and begins a new address byte.
- R9: After a stop condition, the block ignores all bus clocks until the next start condition: it gives no acknowledge and makes no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Selects the two lowest address bits |
| stat_i | input | NSTAT*8 | Status bytes returned by reads; byte i at bits [8i+7:8i] |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| full_field_o | output | 1 | Power-on mode flag, cleared by the first matching access |
| regs_o | output | NREG*8 | Register bank contents; register i at bits [8i+7:8i] |

## Verification
The assertions take for granted that the bus master follows the protocol. SDA changes only while SCL is low, except at start and stop conditions. Each SCL phase lasts several system clocks, so both line edges pass through the synchroniser before the opposite edge arrives. The bench keeps within these limits by moving every line at quarter-bit steps of six clocks, and by building the bus line as the AND of the master's drive and the inverted target enable. Starts and stops are therefore only ever generated while the block is not pulling the line low.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  localparam logic [4:0] ADDR_FIXED = 5'b11011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WRX,
    ST_RTX,
    ST_RACK,
    ST_IGNORE
  } bus_state_t;

  // Full 7-bit target address for a given strap setting
  function automatic logic [6:0] target_addr(input logic [1:0] strap);
    return {ADDR_FIXED, strap};
  endfunction

  // True when the received address byte (address plus direction) selects us
  function automatic logic addr_match(input logic [7:0] rx, input logic [1:0] strap);
    return rx[7:1] == target_addr(strap);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // Data edges while the clock stays high frame a transfer
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_o
);

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_o[i*DW +: DW] <= '0;
        end else if (we && (waddr == AW'(i))) begin
          regs_o[i*DW +: DW] <= wdata;
        end
      end
    end
  endgenerate

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_o[$past(waddr)*DW +: DW] == $past(wdata));

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_strap_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int NSTAT = 4,
  localparam int BW   = 8,
  localparam int RAW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int SAW  = (NSTAT > 1) ? $clog2(NSTAT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [1:0]          strap_i,
  input  logic [NSTAT*BW-1:0] stat_i,
  output logic                sda_oe_o,
  output logic                full_field_o,
  output logic [NREG*BW-1:0]  regs_o
);

  // Arithmetic kept in functions
  function automatic logic [RAW-1:0] reg_next(input logic [RAW-1:0] p);
    return (int'(p) == NREG - 1) ? '0 : RAW'(p + 1'b1);
  endfunction

  function automatic logic [SAW-1:0] stat_next(input logic [SAW-1:0] p);
    return (int'(p) == NSTAT - 1) ? '0 : SAW'(p + 1'b1);
  endfunction

  function automatic logic [RAW-1:0] sub_to_ptr(input logic [BW-1:0] b);
    return RAW'(int'(b) % NREG);
  endfunction

  // Named internal events
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_done, addr_hit, bank_we;

  bus_state_t     state;
  logic [3:0]     cnt;
  logic [BW-1:0]  shreg;
  logic           rw;
  logic           first_byte;
  logic           nack_seen;
  logic [RAW-1:0] wptr;
  logic [SAW-1:0] sptr;
  logic [BW-1:0]  stat_cur, stat_nxt;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign addr_hit  = addr_match(shreg, strap_i);
  assign bank_we   = (state == ST_WRX) && byte_done && !first_byte
                     && !start_evt && !stop_evt;
  assign stat_cur  = stat_i[sptr*BW +: BW];
  assign stat_nxt  = stat_i[stat_next(sptr)*BW +: BW];

  i2c_reg_bank #(.NREG(NREG), .DW(BW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bank_we),
    .waddr  (wptr),
    .wdata  (shreg),
    .regs_o (regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      rw           <= 1'b0;
      first_byte   <= 1'b0;
      nack_seen    <= 1'b0;
      wptr         <= '0;
      sptr         <= '0;
      sda_oe_o     <= 1'b0;
      full_field_o <= 1'b1;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WRX: begin
          if (scl_rise) begin
            shreg <= {shreg[BW-2:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                state        <= ST_ACK;
                sda_oe_o     <= 1'b1;
                rw           <= shreg[0];
                first_byte   <= 1'b1;
                sptr         <= '0;
                full_field_o <= 1'b0;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              state    <= ST_ACK;
              sda_oe_o <= 1'b1;
              if (first_byte) begin
                wptr       <= sub_to_ptr(shreg);
                first_byte <= 1'b0;
              end else begin
                wptr <= reg_next(wptr);
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state    <= ST_RTX;
              shreg    <= stat_cur;
              sda_oe_o <= ~stat_cur[BW-1];
            end else begin
              state    <= ST_WRX;
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_RTX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              state    <= ST_RACK;
              sda_oe_o <= 1'b0;
              cnt      <= '0;
            end else begin
              shreg    <= {shreg[BW-2:0], 1'b0};
              sda_oe_o <= ~shreg[BW-2];
              cnt      <= cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_seen <= sda_s;
          end else if (scl_fall) begin
            if (nack_seen) begin
              state <= ST_IGNORE;
            end else begin
              state    <= ST_RTX;
              sptr     <= stat_next(sptr);
              shreg    <= stat_nxt;
              sda_oe_o <= ~stat_nxt[BW-1];
              cnt      <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe_o) |-> !$past(scl_s));

  // R3
  no_drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe_o);

  // R7
  ff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_field_o |=> !full_field_o);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_oe_o);

  // R8
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR) && (cnt == 4'd0));

endmodule

// File: tb/sim_i2c_strap_target.sv
module sim_i2c_strap_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int NREG       = 4;
  localparam int NSTAT      = 4;
  localparam int LIMIT      = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'd0;
  logic [NSTAT*8-1:0] stat;
  logic sda_oe, ff;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_regs [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_strap_target #(.NREG(NREG), .NSTAT(NSTAT)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_line),
    .strap_i      (strap),
    .stat_i       (stat),
    .sda_oe_o     (sda_oe),
    .full_field_o (ff),
    .regs_o       (regs)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b1; waitq();
  endtask

  // Sends n bits MSB first; flags any target drive during the data bits
  task automatic send_bits(input logic [7:0] b, input int n, output logic drove);
    drove = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; waitq();
      m_scl = 1'b1; waitq();
      if (sda_oe) drove = 1'b1;
      waitq();
      m_scl = 1'b0; waitq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic drove);
    send_bits(b, 8, drove);
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    acked = !sda_line;
    waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitq();
      m_scl = 1'b1; waitq();
      b = {b[6:0], sda_line};
      waitq();
      m_scl = 1'b0;
    end
    waitq();
    m_sda = !master_ack; waitq();
    m_scl = 1'b1; waitq(); waitq();
    m_scl = 1'b0; waitq();
    m_sda = 1'b1;
  endtask

  function automatic logic [31:0] pack_regs();
    logic [31:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_regs[i];
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    m_scl = 1'b1; m_sda = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
  endtask

  task automatic t_reset();
    do_reset();
    chk(ff === 1'b1, "R1", "flag after reset", 32'(ff), 32'd1);
    chk(sda_oe === 1'b0, "R1", "sda enable after reset", 32'(sda_oe), 32'd0);
    chk(regs === '0, "R1", "registers after reset", regs, 32'd0);
  endtask

  task automatic t_mismatch();
    logic a, d;
    strap = 2'd2;
    bus_start();
    send_byte(8'hD8, a, d);
    chk(!a, "R3", "wrong address acked", 32'(a), 32'd0);
    send_byte(8'h00, a, d);
    chk(!a, "R3", "byte after miss acked", 32'(a), 32'd0);
    send_byte(8'h55, a, d);
    chk(!a && !d, "R3", "data after miss acked or driven", 32'({a, d}), 32'd0);
    bus_stop();
    chk(regs === pack_regs(), "R3", "registers after miss", regs, pack_regs());
    chk(ff === 1'b1, "R7", "flag after miss", 32'(ff), 32'd1);
  endtask

  task automatic t_write_wrap();
    logic a, d;
    strap = 2'd2;
    bus_start();
    send_byte(8'hDC, a, d);
    chk(a, "R2", "address DC not acked", 32'(a), 32'd1);
    chk(!d, "R5", "target drove during address bits", 32'(d), 32'd0);
    chk(ff === 1'b0, "R7", "flag after write address", 32'(ff), 32'd0);
    send_byte(8'h06, a, d);
    chk(a, "R4", "sub-address not acked", 32'(a), 32'd1);
    send_byte(8'h11, a, d); exp_regs[2] = 8'h11;
    send_byte(8'h22, a, d); exp_regs[3] = 8'h22;
    send_byte(8'h33, a, d); exp_regs[0] = 8'h33;
    chk(a && !d, "R5", "ack on ninth clock only", 32'({a, d}), 32'b10);
    bus_stop();
    chk(regs === pack_regs(), "R4", "register write with wrap", regs, pack_regs());
    // After stop, clocked bytes without a start are ignored
    send_byte(8'hDC, a, d);
    chk(!a, "R9", "ack after stop without start", 32'(a), 32'd0);
    send_byte(8'hEE, a, d);
    chk(regs === pack_regs(), "R9", "registers after stop", regs, pack_regs());
  endtask

  task automatic t_strap_matrix();
    logic a, d;
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int c = 0; c < 4; c++) begin
        bus_start();
        send_byte({5'b11011, 2'(c), 1'b0}, a, d);
        bus_stop();
        chk(a == (c == s), "R2", $sformatf("strap %0d address %0d", s, c),
            32'(a), 32'(c == s));
      end
    end
  endtask

  task automatic t_read();
    logic a, d;
    logic [7:0] b;
    do_reset();
    strap = 2'd1;
    bus_start();
    send_byte(8'hDB, a, d);
    chk(a, "R2", "read address DB not acked", 32'(a), 32'd1);
    chk(ff === 1'b0, "R7", "flag after read address", 32'(ff), 32'd0);
    for (int k = 0; k < 5; k++) begin
      recv_byte(k < 4, b);
      chk(b === stat[(k % NSTAT)*8 +: 8], "R6", $sformatf("read byte %0d", k),
          32'(b), 32'(stat[(k % NSTAT)*8 +: 8]));
    end
    d = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_scl = 1'b1; waitq(); if (sda_oe) d = 1'b1;
      m_scl = 1'b0; waitq(); if (sda_oe) d = 1'b1;
    end
    chk(!d, "R6", "drive after master NACK", 32'(d), 32'd0);
    bus_stop();
    chk(ff === 1'b0, "R7", "flag stays low", 32'(ff), 32'd0);
  endtask

  task automatic t_restart();
    logic a, d;
    strap = 2'd3;
    bus_start();
    send_bits(8'hDE, 4, d);
    bus_start();
    send_byte(8'hDE, a, d);
    chk(a, "R8", "address after restart in address", 32'(a), 32'd1);
    send_byte(8'h01, a, d);
    send_bits(8'hFF, 3, d);
    bus_start();
    send_byte(8'hDE, a, d);
    chk(a, "R8", "address after restart in data", 32'(a), 32'd1);
    send_byte(8'h00, a, d);
    send_byte(8'h77, a, d); exp_regs[0] = 8'h77;
    bus_stop();
    chk(regs === pack_regs(), "R8", "aborted byte not stored", regs, pack_regs());
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    stat = {8'h0F, 8'hF0, 8'h3C, 8'hA5};
    t_reset();
    t_mismatch();
    t_write_wrap();
    t_strap_matrix();
    t_read();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule